// File: doc/BRIEF.md
# Many-Time-Programmable Byte Flash Mode Decoder

This block is a synthesizable, clock-based model of a byte-wide flash array that is written only by an external programmer. On every cycle it decodes the chip select, output enable and write strobe, together with two digital flags that stand for a high voltage on the output enable pin and on address bit 9, into one operating mode. The modes are standby, read, output off, identification, erase, program, high-voltage hold and inhibit. The data bus is split into an input byte, an output byte and an output enable.

The array is a register memory of `2**ADDR_W` bytes. Programming can only clear bits. The only way to return bits to 1 is an erase of the whole chip. Erase takes a parameterized number of cycles, which stands in for the real erase time. A program needs the write strobe held low for a minimum number of cycles. A shorter or interrupted pulse leaves the byte untouched and raises a sticky error flag.

Control is a three-state machine. `S_IDLE` goes to `S_ERASE` on a falling write strobe in the erase mode, and goes to `S_PROG` on a falling write strobe in the program mode. `S_ERASE` returns to `S_IDLE` when its countdown reaches zero, and fills the array with FFh at that point. `S_PROG` stays put while the program mode holds. It returns to `S_IDLE` on a commit when the strobe rises in the high-voltage hold mode after a long enough pulse. It also returns to `S_IDLE`, with the error flag set, when the pulse is too short or the mode changes to anything else.

Top module: `mtp_flash_model`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `we_n`=1, `oe_hv`=0 and `a9_hv`=0, `dout_en` is 1 and `dout` equals the stored byte at `addr`, in the same cycle.
- R2: Whenever `ce_n`=1, `oe_n`=1 or `oe_hv`=1, `dout_en` is 0 and `dout` reads 00h.
- R3: With `ce_n`=1 (standby), a falling `we_n` starts nothing, whatever the other inputs are. `busy` stays 0 and the array is unchanged.
- R4: A falling `we_n` with `ce_n`=0, `oe_hv`=1 and `a9_hv`=1 starts an erase, and `addr` and `din` are ignored. `busy` is 1 for exactly `ERASE_CYC` cycles from the first clock edge that sees `we_n` low. After that every byte reads FFh.
- R5: A falling `we_n` with `ce_n`=0, `oe_hv`=1 and `a9_hv`=0 captures `addr` and `din` at that edge. Count the clock edges that see `we_n` low. If that count is at least `PROG_MIN` when `we_n` returns high (with `ce_n`=0 and `oe_hv`=1 still held), the byte becomes old AND `din`.
- R6: A pulse that is too short, or that ends with `ce_n` rising, `oe_hv` dropping or `a9_hv` rising, leaves the byte unchanged and sets `pulse_err` to 1. The next successful program clears `pulse_err`.
- R7: With `ce_n`=0, `oe_n`=0, `we_n`=1, `oe_hv`=0 and `a9_hv`=1 (identification), only `addr[0]` selects the output. It gives BFh when `addr[0]` is 0. When it is 1, it gives the device code for `ADDR_W`: 16 gives C4h, 17 gives C5h, 18 gives C6h and 19 gives C2h. Any other width gives C4h.
- R8: With `oe_hv`=0, a falling `we_n` never writes or erases. With `oe_hv`=1, nothing starts unless `we_n` actually falls.
- R9: A synchronous reset `rst` returns the machine to idle with `busy`=0 and `pulse_err`=0, aborts a running erase and keeps the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_hv | input | 1 | High voltage present on the output enable pin |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte read out, 00h when not driven |
| dout_en | output | 1 | Output driver enable |
| busy | output | 1 | Erase in progress |
| pulse_err | output | 1 | Last program pulse was rejected |

## Verification
Two situations are hard to reach from the ports. The first is a program pulse whose length sits exactly on the `PROG_MIN` boundary. The second is a pulse cut short by a change of chip select, because the write strobe must fall in one mode and rise in another. The bench builds each case from tasks that drive the strobe at the falling clock edge for a counted number of edges, so the edge count is known exactly. It also raises reset partway through an erase countdown, then reads an address back to show that the fill never happened. Contents are swept over the whole small array twice, with two arithmetic patterns, to check that programming only clears bits.

// File: rtl/mtp_flash_pkg.sv
package mtp_flash_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUT_OFF,
        M_IDENT,
        M_ERASE,
        M_PROG,
        M_HV_WAIT,
        M_INHIBIT
    } mode_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ERASE,
        S_PROG
    } state_t;

    localparam logic [7:0] MFG_CODE = 8'hBF;

    function automatic logic [7:0] dev_code(input int aw);
        case (aw)
            17:      return 8'hC5;
            18:      return 8'hC6;
            19:      return 8'hC2;
            default: return 8'hC4;
        endcase
    endfunction

endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
    import mtp_flash_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic              addr0,
    input  logic [7:0]        rd_data,
    output mode_t             mode,
    output logic [7:0]        dout,
    output logic              dout_en
);
    localparam logic [7:0] DEV = dev_code(ADDR_W);

    always_comb begin
        if (ce_n)
            mode = M_STANDBY;
        else if (oe_hv)
            mode = we_n ? M_HV_WAIT : (a9_hv ? M_ERASE : M_PROG);
        else if (oe_n)
            mode = M_OUT_OFF;
        else if (!we_n)
            mode = M_INHIBIT;
        else
            mode = a9_hv ? M_IDENT : M_READ;
    end

    always_comb begin
        dout_en = 1'b0;
        dout    = 8'h00;
        if (mode == M_READ) begin
            dout_en = 1'b1;
            dout    = rd_data;
        end else if (mode == M_IDENT) begin
            dout_en = 1'b1;
            dout    = addr0 ? DEV : MFG_CODE;
        end
    end

endmodule

// File: rtl/mtp_op_ctrl.sv
module mtp_op_ctrl
    import mtp_flash_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PROG_MIN  = 4,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              busy,
    output logic              pulse_err,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              erase_all
);
    localparam int CW = $clog2(PROG_MIN + 1);
    localparam int EW = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;
    localparam logic [CW-1:0] CMAX  = CW'(PROG_MIN);
    localparam logic [EW-1:0] ELOAD = EW'(ERASE_CYC - 1);

    state_t          st, nxt;
    logic            we_q;
    logic [CW-1:0]   pcnt;
    logic [EW-1:0]   ecnt;
    logic            we_fall;
    logic            err_set;

    assign we_fall = we_q && !we_n;
    assign busy    = (st == S_ERASE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    // next state and strobes
    always_comb begin
        nxt       = st;
        wr_en     = 1'b0;
        erase_all = 1'b0;
        err_set   = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (we_fall && mode == M_ERASE)     nxt = S_ERASE;
                else if (we_fall && mode == M_PROG) nxt = S_PROG;
            end
            S_ERASE: begin
                if (ecnt == '0) begin
                    erase_all = 1'b1;
                    nxt       = S_IDLE;
                end
            end
            S_PROG: begin
                if (mode != M_PROG) begin
                    nxt = S_IDLE;
                    if (mode == M_HV_WAIT && pcnt >= CMAX) wr_en = 1'b1;
                    else                                    err_set = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= 1'b1;
            pcnt      <= '0;
            ecnt      <= '0;
            pulse_err <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            we_q <= we_n;
            if (st == S_IDLE && nxt == S_PROG) begin
                pcnt    <= CW'(1);
                wr_addr <= addr;
                wr_data <= din;
            end else if (st == S_PROG && mode == M_PROG && pcnt != CMAX) begin
                pcnt <= pcnt + CW'(1);
            end
            if (st == S_IDLE && nxt == S_ERASE) ecnt <= ELOAD;
            else if (st == S_ERASE && ecnt != '0) ecnt <= ecnt - EW'(1);
            if (wr_en)        pulse_err <= 1'b0;
            else if (err_set) pulse_err <= 1'b1;
        end
    end

    generate
        if (ERASE_CYC > 1) begin : g_erase_hold
            p_erase_holds_r4: assert property (@(posedge clk) disable iff (rst)
                $rose(busy) |=> busy);
        end
    endgenerate

    p_err_from_prog_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_err) |-> $past(st) == S_PROG);

    p_standby_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && mode == M_STANDBY) |=> st == S_IDLE);

endmodule

// File: rtl/mtp_array.sv
module mtp_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_all,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] wr_old;

    assign rd_data = mem[rd_addr];
    assign wr_old  = mem[wr_addr];

    always_ff @(posedge clk) begin
        if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_old & wr_data;
        end
    end

    p_only_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !erase_all) |=> (wr_old & ~$past(wr_old)) == 8'h00);

    p_erase_fill_r4: assert property (@(posedge clk) disable iff (rst)
        erase_all |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/mtp_flash_model.sv
module mtp_flash_model
    import mtp_flash_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PROG_MIN  = 4,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy,
    output logic              pulse_err
);
    mode_t             mode;
    logic [7:0]        rd_data;
    logic              wr_en;
    logic              erase_all;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    mtp_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .oe_hv(oe_hv), .a9_hv(a9_hv),
        .addr0(addr[0]), .rd_data(rd_data), .mode(mode),
        .dout(dout), .dout_en(dout_en)
    );

    mtp_op_ctrl #(.ADDR_W(ADDR_W), .PROG_MIN(PROG_MIN), .ERASE_CYC(ERASE_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .mode(mode), .we_n(we_n), .addr(addr), .din(din),
        .busy(busy), .pulse_err(pulse_err), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_all(erase_all)
    );

    mtp_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst(rst), .erase_all(erase_all), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data)
    );

    p_out_off_r2: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n || oe_hv) |-> (!dout_en && dout == 8'h00));

    p_write_needs_hv_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en || erase_all) |-> $past(oe_hv));

endmodule

// File: tb/mtp_flash_model_bench.sv
module mtp_flash_model_bench;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int PMIN  = 4;
    localparam int ECYC  = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, busy, pulse_err;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] shadow [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    mtp_flash_model #(.ADDR_W(AW), .PROG_MIN(PMIN), .ERASE_CYC(ECYC)) u_mtp_flash_model (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .oe_hv(oe_hv),
        .a9_hv(a9_hv), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .busy(busy), .pulse_err(pulse_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0;
    endtask

    task automatic read_at(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; addr = a;
        #1;
        chk(req, {dout_en, dout}, {1'b1, shadow[a]});
    endtask

    // drive a program pulse with n edges seeing we_n low
    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input int n);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; a9_hv = 1'b0; we_n = 1'b1;
        addr = a; din = d;
        @(negedge clk);
        we_n = 1'b0;
        repeat (n) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        oe_hv = 1'b0;
        if (n >= PMIN) shadow[a] = shadow[a] & d;
    endtask

    task automatic erase_chip();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; a9_hv = 1'b1; we_n = 1'b1;
        addr = 6'h2A; din = 8'h00;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        chk("R4 busy set", busy, 1);
        we_n = 1'b1;
        repeat (ECYC - 1) @(negedge clk);
        chk("R4 busy last cycle", busy, 1);
        @(negedge clk);
        chk("R4 busy clear", busy, 0);
        set_idle();
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    endtask

    function automatic logic [7:0] pat1(input int a);
        return 8'((a * 37 + 5) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] pat2(input int a);
        return 8'(~(a * 11 + 3));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R9 reset pulse_err", pulse_err, 0);
        chk("R2 standby dout_en", dout_en, 0);
        rst = 1'b0;

        // R4: full erase, then sweep R1 reads
        erase_chip();
        for (int i = 0; i < DEPTH; i++) read_at(AW'(i), "R1/R4 read after erase");

        // R5: exact minimum pulse, then a longer one, AND accumulation
        for (int i = 0; i < DEPTH; i++) prog(AW'(i), pat1(i), PMIN);
        for (int i = 0; i < DEPTH; i++) read_at(AW'(i), "R5 program pattern one");
        for (int i = 0; i < DEPTH; i++) prog(AW'(i), pat2(i), PMIN + 3);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ce_n = 1'b0; oe_n = 1'b0; oe_hv = 1'b0; a9_hv = 1'b0; addr = AW'(i);
            #1;
            chk("R5 old AND new", dout, 8'hFF & pat1(i) & pat2(i));
        end
        chk("R6 no error after good pulses", pulse_err, 0);

        // R6: short pulse
        prog(6'd3, 8'h00, PMIN - 1);
        chk("R6 short pulse flag", pulse_err, 1);
        read_at(6'd3, "R6 short pulse unchanged");
        prog(6'd3, 8'hFF, PMIN);
        chk("R6 flag cleared", pulse_err, 0);

        // R6: abort by chip select
        @(negedge clk);
        ce_n = 1'b0; oe_hv = 1'b1; a9_hv = 1'b0; addr = 6'd4; din = 8'h00;
        @(negedge clk); we_n = 1'b0;
        repeat (PMIN + 1) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); oe_hv = 1'b0;
        chk("R6 abort flag", pulse_err, 1);
        read_at(6'd4, "R6 abort unchanged");

        // R5: address and data captured at the falling edge
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; a9_hv = 1'b0; addr = 6'd5; din = 8'h00;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = 6'd6; din = 8'hFF;
        repeat (PMIN) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk); oe_hv = 1'b0;
        shadow[5] = 8'h00;
        read_at(6'd5, "R5 latched address written");
        read_at(6'd6, "R5 changed address untouched");

        // R7: identification
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b1; addr = 6'd0;
        #1; chk("R7 maker code", {dout_en, dout}, {1'b1, 8'hBF});
        addr = 6'd1;
        #1; chk("R7 device code", {dout_en, dout}, {1'b1, 8'hC4});
        addr = 6'd2;
        #1; chk("R7 only bit 0 selects", dout, 8'hBF);

        // R2: enable sweep
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            ce_n = k[0]; oe_n = k[1]; oe_hv = k[2]; we_n = 1'b1; a9_hv = 1'b0; addr = 6'd7;
            #1;
            if (k == 0) chk("R1 enable sweep", {dout_en, dout}, {1'b1, shadow[7]});
            else        chk("R2 enable sweep", {dout_en, dout}, 9'h000);
        end
        set_idle();

        // R8: strobe with normal output enable
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b0; a9_hv = k[0]; addr = 6'd8; din = 8'h00;
            @(negedge clk); we_n = 1'b0;
            repeat (PMIN + 2) @(negedge clk);
            we_n = 1'b1;
            @(negedge clk);
            chk("R8 no erase without hv", busy, 0);
            read_at(6'd8, "R8 no write without hv");
        end
        // R8: hv raised while strobe already low
        @(negedge clk);
        ce_n = 1'b0; oe_hv = 1'b0; a9_hv = 1'b0; addr = 6'd9; din = 8'h00; we_n = 1'b0;
        @(negedge clk); oe_hv = 1'b1;
        repeat (PMIN + 2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk); oe_hv = 1'b0;
        read_at(6'd9, "R8 no falling edge no write");

        // R3: standby ignores an erase strobe
        @(negedge clk);
        ce_n = 1'b1; oe_hv = 1'b1; a9_hv = 1'b1; we_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk);
        chk("R3 standby no busy", busy, 0);
        we_n = 1'b1;
        repeat (ECYC + 2) @(negedge clk);
        set_idle();
        read_at(6'd10, "R3 standby array kept");

        // R9: reset in mid erase
        @(negedge clk);
        ce_n = 1'b0; oe_hv = 1'b1; a9_hv = 1'b1; we_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; we_n = 1'b1;
        chk("R9 reset aborts erase", busy, 0);
        set_idle();
        repeat (ECYC + 2) @(negedge clk);
        read_at(6'd11, "R9 array kept through reset");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule